// File: doc/BRIEF.md
# Scaled Integer Add Execution Unit

This unit executes one scaled integer add per cycle for a shader-style integer pipeline. The issue stage hands it a 64-bit instruction word, a form select, the A operand and the B operand. Both operands are already fetched: B may have come from a register, a constant buffer or an immediate. The unit decodes the control fields from the instruction word. It applies the optional negations, or the plus-one mode when both negate bits are set. It then shifts A left by a 5-bit amount and adds B.

One cycle after a valid input, the unit presents the 32-bit result and the destination register index. It also presents a four-bit condition flag vector and a flag-write enable. The flag vector is held in an output register, and it only changes when the instruction asks for a flag update.

The output stage is a two-state machine. `ST_IDLE` means no result is presented. `ST_HOLD` means a result is presented on the outputs. There are four transitions:
- `ISSUE`: `ST_IDLE` to `ST_HOLD` when the input is valid.
- `STREAM`: `ST_HOLD` to `ST_HOLD` when the input is valid.
- `DRAIN`: `ST_HOLD` to `ST_IDLE` when the input is not valid.
- `REST`: `ST_IDLE` to `ST_IDLE` when the input is not valid.

Top module: `scaled_add_unit`

## Requirements
- R1: The destination index output equals instruction bits [7:0] of the accepted instruction, in every form.
- R2: In forms 0 (register), 1 (constant) and 2 (20-bit immediate), the following instruction bits control the operation:
  - bit 47 requests a flag update;
  - bit 48 negates B;
  - bit 49 negates A;
  - bits [43:39] give the shift amount.
- R3: In form 3 (32-bit immediate), bit 52 requests a flag update and bits [57:53] give the shift amount. Bits 48 and 49 have no effect in this form, and no negation is applied.
- R4: When exactly one negate bit is set, that operand is replaced by its two's-complement negation before the shift and the add.
- R5: When both negate bits are set (plus-one mode), neither operand is negated and B is replaced by B+1, modulo 2^32.
- R6: The result is ((processed A) << shift) + (processed B), truncated to 32 bits. The shift is logical.
- R7: The flag vector is laid out as bit 3 zero, bit 2 sign, bit 1 carry and bit 0 overflow. On an update, zero is set when the result is 0 and sign copies result bit 31.
- R8: On an update, carry is the carry-out of the final add and overflow is its signed overflow. In plus-one mode, carry is also set when B was 0xFFFFFFFF, and overflow is also set when B was 0x7FFFFFFF.
- R9: When no flag update is requested, the flag-write enable output is low and the flag vector keeps its previous value.
- R10: A valid input produces a valid output, with its result, exactly one cycle later. Without a valid input, the output valid is low on the next cycle and the flag-write enable is low.
- R11: A synchronous active-high reset clears the output valid, the flag-write enable and the flag vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 64 | Instruction word |
| in_form | input | 2 | Operand form: 0 register, 1 constant, 2 imm20, 3 imm32 |
| in_a | input | 32 | A operand value |
| in_b | input | 32 | B operand value, already fetched |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Sum result |
| out_dest | output | 8 | Destination register index |
| out_flags | output | 4 | Flag register {zero, sign, carry, overflow} |
| out_flag_we | output | 1 | Flags were written by this result |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath and a 5-bit shift field. These widths make every corner reachable: shift amounts 0 and 31, increments from 0x7FFFFFFF and 0xFFFFFFFF, and adds that wrap exactly to zero. A behavioural model in the bench computes the result and the flags with 64-bit integer arithmetic. The bench compares the model with the outputs on every cycle. Directed cases cover the negate and plus-one modes, the imm32 form with stray negate bits, and runs with flag updates disabled. A seeded random run then mixes the forms, the valid gaps and the operand values.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
    localparam int DATA_W   = 32;
    localparam int INSTR_W  = 64;
    localparam int REG_W    = 8;
    localparam int SHAMT_W  = 5;

    // field positions the decoder relies on
    localparam int DEST_LO   = 0;
    localparam int STD_UPD   = 47;
    localparam int STD_NEGB  = 48;
    localparam int STD_NEGA  = 49;
    localparam int STD_SH_LO = 39;
    localparam int I32_UPD   = 52;
    localparam int I32_SH_LO = 53;

    typedef enum logic [1:0] {
        FORM_REG   = 2'd0,
        FORM_CBUF  = 2'd1,
        FORM_IMM20 = 2'd2,
        FORM_IMM32 = 2'd3
    } form_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } flags_t;

    typedef struct packed {
        logic [REG_W-1:0]   dest;
        logic               upd;
        logic               neg_a;
        logic               neg_b;
        logic [SHAMT_W-1:0] shamt;
    } ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } out_state_e;
endpackage

// File: rtl/sadd_decode.sv
module sadd_decode
    import sadd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  form_e              form,
    output ctl_t               ctl
);
    always_comb begin
        ctl.dest = instr[DEST_LO +: REG_W];
        unique case (form)
            FORM_IMM32: begin
                ctl.upd   = instr[I32_UPD];
                ctl.neg_a = 1'b0;
                ctl.neg_b = 1'b0;
                ctl.shamt = instr[I32_SH_LO +: SHAMT_W];
            end
            default: begin
                ctl.upd   = instr[STD_UPD];
                ctl.neg_a = instr[STD_NEGA];
                ctl.neg_b = instr[STD_NEGB];
                ctl.shamt = instr[STD_SH_LO +: SHAMT_W];
            end
        endcase
    end

    // bits consumed by other stages (A source index, immediates, opcode)
    logic unused_instr;
    assign unused_instr = ^{instr[INSTR_W-1:I32_SH_LO+SHAMT_W],
                            instr[I32_UPD-1:STD_NEGA+1],
                            instr[STD_UPD-1:STD_SH_LO+SHAMT_W],
                            instr[STD_SH_LO-1:DEST_LO+REG_W]};
endmodule

// File: rtl/sadd_operand.sv
module sadd_operand #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         neg_a,
    input  logic         neg_b,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         plus_one,
    output logic         inc_carry,
    output logic         inc_ovf
);
    logic [W-1:0] b_inc;

    assign plus_one = neg_a & neg_b;
    assign {inc_carry, b_inc} = {1'b0, b_in} + {{W{1'b0}}, 1'b1};
    assign inc_ovf = ~b_in[W-1] & b_inc[W-1];

    always_comb begin
        if (plus_one) begin
            a_out = a_in;
            b_out = b_inc;
        end else begin
            a_out = neg_a ? (~a_in + 1'b1) : a_in;
            b_out = neg_b ? (~b_in + 1'b1) : b_in;
        end
    end
endmodule

// File: rtl/sadd_core.sv
module sadd_core
    import sadd_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  a_p,
    input  logic [W-1:0]  b_p,
    input  logic [SW-1:0] shamt,
    input  logic          plus_one,
    input  logic          inc_carry,
    input  logic          inc_ovf,
    output logic [W-1:0]  sum,
    output flags_t        flags
);
    localparam int MSB = W - 1;
    logic [W-1:0] scaled;
    logic         add_c;
    logic         add_v;

    assign scaled = a_p << shamt;
    assign {add_c, sum} = {1'b0, scaled} + {1'b0, b_p};
    assign add_v = (scaled[MSB] == b_p[MSB]) && (sum[MSB] != scaled[MSB]);

    always_comb begin
        flags.zero  = (sum == '0);
        flags.sign  = sum[MSB];
        flags.carry = add_c | (plus_one & inc_carry);
        flags.ovf   = add_v | (plus_one & inc_ovf);
    end
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
    import sadd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_instr,
    input  logic [1:0]  in_form,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic [7:0]  out_dest,
    output logic [3:0]  out_flags,
    output logic        out_flag_we
);
    ctl_t         ctl;
    logic [31:0]  a_p, b_p, sum;
    logic         plus_one, inc_c, inc_v;
    flags_t       nf;
    out_state_e   state, state_nx;

    sadd_decode u_dec (
        .instr (in_instr),
        .form  (form_e'(in_form)),
        .ctl   (ctl)
    );

    sadd_operand #(.W(DATA_W)) u_opr (
        .a_in      (in_a),
        .b_in      (in_b),
        .neg_a     (ctl.neg_a),
        .neg_b     (ctl.neg_b),
        .a_out     (a_p),
        .b_out     (b_p),
        .plus_one  (plus_one),
        .inc_carry (inc_c),
        .inc_ovf   (inc_v)
    );

    sadd_core #(.W(DATA_W), .SW(SHAMT_W)) u_core (
        .a_p       (a_p),
        .b_p       (b_p),
        .shamt     (ctl.shamt),
        .plus_one  (plus_one),
        .inc_carry (inc_c),
        .inc_ovf   (inc_v),
        .sum       (sum),
        .flags     (nf)
    );

    // next-state: ISSUE / STREAM / DRAIN / REST
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_nx = in_valid ? ST_HOLD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign out_valid = (state == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result  <= '0;
            out_dest    <= '0;
            out_flags   <= '0;
            out_flag_we <= 1'b0;
        end else begin
            out_flag_we <= in_valid & ctl.upd;
            if (in_valid) begin
                out_result <= sum;
                out_dest   <= ctl.dest;
                if (ctl.upd) out_flags <= nf;
            end
        end
    end

    // ---------------- assertions ----------------
    a_r3_imm32_no_neg: assert property (@(posedge clk) disable iff (rst)
        (in_form == 2'd3) |-> (!ctl.neg_a && !ctl.neg_b));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r10_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_flag_we |-> out_valid);

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !out_flag_we) |-> $stable(out_flags));

    a_r7_zero_sign: assert property (@(posedge clk) disable iff (rst)
        out_flag_we |-> (out_flags[3] == (out_result == 32'd0)
                         && out_flags[2] == out_result[31]));
endmodule

// File: tb/test_scaled_add_unit.sv
module test_scaled_add_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_instr = '0;
    logic [1:0]  in_form = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        out_valid, out_flag_we;
    logic [31:0] out_result;
    logic [7:0]  out_dest;
    logic [3:0]  out_flags;

    int n_chk = 0, n_fail = 0;
    string cur_tag = "R6";

    always #2.5 clk = ~clk;

    scaled_add_unit i_scaled_add_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_form(in_form), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_dest(out_dest), .out_flags(out_flags),
        .out_flag_we(out_flag_we)
    );

    // ---------- reference model ----------
    logic        e_valid = 1'b0, e_we = 1'b0;
    logic [31:0] e_res = '0;
    logic [7:0]  e_dest = '0;
    logic [3:0]  e_flags = '0;
    string       e_tag = "R6";

    task automatic ref_calc(input logic [63:0] ins, input logic [1:0] f,
                            input logic [31:0] a, input logic [31:0] b,
                            output logic [31:0] res, output logic [3:0] fl,
                            output logic upd);
        logic na, nb, po, c, o;
        int unsigned sc;
        logic [31:0] ap, bp, sa;
        longint unsigned wide;
        if (f == 2'd3) begin
            upd = ins[52]; na = 0; nb = 0; sc = ins[57:53];
        end else begin
            upd = ins[47]; nb = ins[48]; na = ins[49]; sc = ins[43:39];
        end
        po = na && nb;
        ap = (na && !po) ? 32'(0 - a) : a;
        bp = po ? 32'(b + 1) : (nb ? 32'(0 - b) : b);
        sa = 32'(ap << sc);
        wide = longint'(sa) + longint'(bp);
        res = wide[31:0];
        c = wide[32];
        o = (sa[31] == bp[31]) && (res[31] != sa[31]);
        if (po) begin
            c = c | (b == 32'hFFFF_FFFF);
            o = o | (b == 32'h7FFF_FFFF);
        end
        fl = {res == 0, res[31], c, o};
    endtask

    always @(posedge clk) begin
        logic [31:0] r; logic [3:0] fl; logic u;
        ref_calc(in_instr, in_form, in_a, in_b, r, fl, u);
        if (rst) begin
            e_valid <= 0; e_we <= 0; e_flags <= 0;
        end else begin
            e_valid <= in_valid;
            e_we    <= in_valid && u;
            e_tag   <= cur_tag;
            if (in_valid) begin
                e_res  <= r;
                e_dest <= in_instr[7:0];
                if (u) e_flags <= fl;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R10 valid", 32'(out_valid), 32'(e_valid));
        chk("R9 flag_we", 32'(out_flag_we), 32'(e_we));
        chk({e_tag, "/R7/R8 flags"}, 32'(out_flags), 32'(e_flags));
        if (e_valid) begin
            chk({e_tag, "/R6 result"}, out_result, e_res);
            chk("R1 dest", 32'(out_dest), 32'(e_dest));
        end
    endtask

    function automatic logic [63:0] mk_std(input logic [7:0] d, input logic cc,
                                          input logic na, input logic nb, input logic [4:0] sc);
        logic [63:0] w = '0;
        w[7:0] = d; w[15:8] = 8'h11; w[47] = cc; w[48] = nb; w[49] = na; w[43:39] = sc;
        return w;
    endfunction

    function automatic logic [63:0] mk_i32(input logic [7:0] d, input logic cc, input logic [4:0] sc);
        logic [63:0] w = '0;
        w[7:0] = d; w[52] = cc; w[57:53] = sc;
        w[49] = 1'b1; w[48] = 1'b1; w[47] = ~cc; w[43:39] = 5'd7; // must be ignored (R3)
        return w;
    endfunction

    task automatic step(input string tag, input logic v, input logic [63:0] ins,
                        input logic [1:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        compare();
        cur_tag = tag; in_valid = v; in_instr = ins; in_form = f; in_a = a; in_b = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11 valid after reset", 32'(out_valid), 32'd0);
        chk("R11 flags after reset", 32'(out_flags), 32'd0);
        chk("R11 we after reset", 32'(out_flag_we), 32'd0);
        // R6, R2: plain add with scale, all three standard forms
        step("R6", 1, mk_std(8'h05, 1, 0, 0, 5'd4), 2'd0, 32'h0000_0003, 32'h0000_0010);
        step("R2", 1, mk_std(8'hA2, 1, 0, 0, 5'd0), 2'd1, 32'h8000_0000, 32'h8000_0000);
        step("R2", 1, mk_std(8'h33, 1, 0, 0, 5'd31), 2'd2, 32'h0000_0001, 32'h0000_0001);
        // R4: single negations
        step("R4", 1, mk_std(8'h01, 1, 1, 0, 5'd1), 2'd0, 32'h0000_0002, 32'h0000_0004);
        step("R4", 1, mk_std(8'h02, 1, 0, 1, 5'd2), 2'd0, 32'h0000_0001, 32'h0000_0004);
        // R5, R8: plus-one mode with increment carry and overflow
        step("R5", 1, mk_std(8'h03, 1, 1, 1, 5'd0), 2'd0, 32'h0000_0000, 32'hFFFF_FFFF);
        step("R5", 1, mk_std(8'h04, 1, 1, 1, 5'd0), 2'd2, 32'h0000_0000, 32'h7FFF_FFFF);
        step("R8", 1, mk_std(8'h06, 1, 1, 1, 5'd3), 2'd1, 32'h1234_5678, 32'h0000_0009);
        // R7: result wraps to zero
        step("R7", 1, mk_std(8'h07, 1, 0, 0, 5'd0), 2'd0, 32'hFFFF_FFFF, 32'h0000_0001);
        // R9: no update keeps flags
        step("R9", 1, mk_std(8'h08, 0, 0, 0, 5'd0), 2'd0, 32'h7FFF_FFFF, 32'h0000_0001);
        // R3: imm32 form ignores negate bits and uses its own fields
        step("R3", 1, mk_i32(8'h09, 1, 5'd2), 2'd3, 32'hFFFF_FFFE, 32'h0000_0010);
        step("R3", 1, mk_i32(8'h0A, 0, 5'd31), 2'd3, 32'h0000_0003, 32'h0000_0000);
        // R10: gap in valid
        step("R10", 0, '0, 2'd0, 32'd0, 32'd0);
        step("R10", 0, '0, 2'd0, 32'd0, 32'd0);
        for (int i = 0; i < 400; i++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            step("R6", ($urandom % 4) != 0, w, 2'($urandom), $urandom,
                 (i % 7 == 0) ? 32'h7FFF_FFFF : (i % 11 == 0) ? 32'hFFFF_FFFF : $urandom);
        end
        step("R10", 0, '0, 2'd0, 32'd0, 32'd0);
        step("R10", 0, '0, 2'd0, 32'd0, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule